// File: doc/BRIEF.md
# Multiplexed-Address DRAM Functional Model

This block is a synthesizable model of a four-bit-wide dynamic RAM whose row and column addresses share one bus. It is a target for a memory controller under test. All strobes (row strobe, column strobe, write enable, output enable) are active low. They are sampled on the system clock like ordinary synchronous inputs, and every edge is found by comparing the current sample with the one before it. The model latches the row half of the address when the row strobe falls and the column half when the column strobe falls. It then reads or writes an internal cell array.

The kind of cycle is worked out only from the order of the strobe edges. The model handles read, early write, delayed write (including read-modify-write), fast page access, row-only refresh, column-before-row refresh and hidden refresh. Read data appears on `dout` with a qualifying flag `dout_en`. While the flag is low, `dout` is zero, which stands for high impedance. A one-cycle `proto_err` pulse flags a column strobe that falls too soon after its precharge, or a column access when no row is open.

The data path has no valid/ready handshake. The strobe sequence itself paces every transfer, so the model applies no back-pressure and the controller must follow the strobe protocol. Every effect of a strobe edge becomes visible at the outputs right after the clock edge that first samples the new strobe level. The array depth is a parameter. The array index is the low bits of the concatenation {row, column}, so a reduced depth makes high row bits alias.

Top module: `dram_fn_model`

## Requirements
- R1: After reset `dout_en` and `proto_err` are 0 and `dout` is 0.
- R2: The row is taken from `addr` at the sample where `ras_n` falls, and the column at the sample where `cas_n` falls. The cell used is bits [IDX_W-1:0] of {row, column}, where IDX_W = log2(DEPTH). With the default DEPTH of 1024, rows that differ only above bit 0 hit the same cell.
- R3: If `we_n` is low at the sample where `cas_n` falls (early write), `din` from that sample is stored at the addressed cell.
- R4: If `we_n` falls while `cas_n` is low after a read-type column access (delayed write or read-modify-write), `din` from that sample is stored at the latched column.
- R5: On a read (`we_n` high at the `cas_n` fall), `dout_en` is 0 before the fall. After the fall it is 1, with the cell value on `dout`, in every sample where `oe_n` is low. It returns to 0 at the sample where `cas_n` or `oe_n` is high.
- R6: During a read `din` has no effect: the cell keeps its value.
- R7: In an early write cycle `dout_en` stays 0 for the whole cycle, even with `oe_n` low.
- R8: If `cas_n` is already low when `ras_n` falls, the cycle is a column-before-row refresh. It uses no address, writes nothing, and leaves `dout_en` at 0.
- R9: A row-strobe-only cycle with no column fall (row-only refresh) changes no cell, and `dout_en` stays 0 even with `we_n` and `oe_n` low.
- R10: If `cas_n` stays low while `ras_n` rises and falls again (hidden refresh), `dout` and `dout_en` keep the read data until `cas_n` rises.
- R11: With `ras_n` held low, each new `cas_n` fall latches a new column in the same open row and performs a read or early write (fast page).
- R12: `proto_err` pulses for one sample when `cas_n` falls while `ras_n` is high and `cas_n` was sampled high in fewer than PRECHARGE_CYC consecutive samples before the fall.
- R13: `proto_err` pulses for one sample when `cas_n` falls during a column-before-row refresh (no row open). That fall writes no cell and drives no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Shared row/column address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | High while `dout` is driven |
| proto_err | output | 1 | One-sample strobe protocol error pulse |

## Verification
The hardest case to reach from the ports is the hidden refresh. Read data has to survive a row strobe that rises and falls again while the column strobe never moves. That only happens if a complete read is set up first and the row strobe is then cycled without releasing the column strobe. A second hard case is the column access with no row open: the column strobe must be lowered before the row strobe, then raised and lowered again inside that refresh cycle. The column used is one written earlier under the row that was last latched, so a stray write to the old row would change a value the bench reads back.

// File: rtl/dram_fm_pkg.sv
package dram_fm_pkg;

  // Phase of the row-strobe cycle as seen by the controller.
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,  // row strobe high
    PH_ROW  = 3'd1,  // row latched, no column yet
    PH_COL  = 3'd2,  // column strobe low, access active
    PH_PAGE = 3'd3,  // row open, column strobe precharging
    PH_RFSH = 3'd4   // column-before-row refresh, no row open
  } phase_t;

endpackage

// File: rtl/dram_strobe_sampler.sv
module dram_strobe_sampler #(
  parameter int PRECHARGE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic oe_n,
  output logic ras_q,
  output logic cas_q,
  output logic oe_q,
  output logic ras_fall,
  output logic ras_rise,
  output logic cas_fall,
  output logic cas_rise,
  output logic we_fall,
  output logic pre_ok
);

  localparam int CNT_W = $clog2(PRECHARGE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PRECHARGE_CYC);

  logic we_q;
  logic [CNT_W-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      we_q  <= 1'b1;
      oe_q  <= 1'b1;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      we_q  <= we_n;
      oe_q  <= oe_n;
    end
  end

  // Consecutive samples with the column strobe high, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hi_cnt <= CNT_MAX;
    else if (!cas_n)
      hi_cnt <= '0;
    else if (hi_cnt != CNT_MAX)
      hi_cnt <= hi_cnt + 1'b1;
  end

  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n;
  assign cas_fall = cas_q & ~cas_n;
  assign cas_rise = ~cas_q & cas_n;
  assign we_fall  = we_q & ~we_n;
  assign pre_ok   = (hi_cnt == CNT_MAX);

  assert_cas_low_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n) |=> (!pre_ok || PRECHARGE_CYC == 0));

endmodule

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl
  import dram_fm_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cas_q,
  input  logic              ras_fall,
  input  logic              ras_rise,
  input  logic              cas_fall,
  input  logic              cas_rise,
  input  logic              we_fall,
  input  logic              pre_ok,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_idx,
  output logic              rd_load,
  output logic              valid_q,
  output logic              early_q,
  output logic              err_q
);

  localparam int FULL_W = 2 * ADDR_W;

  phase_t            ph_q, ph_d;
  logic [ADDR_W-1:0] row_q, row_d, col_q, col_d;
  logic              valid_d, early_d, err_d;
  logic [FULL_W-1:0] full_addr;

  // A column fall uses the live bus, anything later the latched column.
  assign full_addr = cas_fall ? {row_q, addr} : {row_q, col_q};
  assign mem_idx   = full_addr[IDX_W-1:0];

  always_comb begin
    ph_d    = ph_q;
    row_d   = row_q;
    col_d   = col_q;
    valid_d = valid_q;
    early_d = early_q;
    err_d   = 1'b0;
    mem_we  = 1'b0;
    rd_load = 1'b0;
    if (cas_rise) begin
      valid_d = 1'b0;
      early_d = 1'b0;
    end
    unique case (ph_q)
      PH_IDLE: begin
        if (ras_fall) begin
          if (!cas_q) begin
            ph_d = PH_RFSH;
          end else begin
            ph_d  = PH_ROW;
            row_d = addr;
          end
          if (cas_fall) err_d = 1'b1;
        end else if (cas_fall && !pre_ok) begin
          err_d = 1'b1;
        end
      end
      PH_ROW, PH_PAGE: begin
        if (ras_rise) begin
          ph_d = PH_IDLE;
        end else if (cas_fall) begin
          ph_d  = PH_COL;
          col_d = addr;
          if (!we_n) begin
            mem_we  = 1'b1;
            early_d = 1'b1;
            valid_d = 1'b0;
          end else begin
            rd_load = 1'b1;
            valid_d = 1'b1;
            early_d = 1'b0;
          end
        end
      end
      PH_COL: begin
        if (ras_rise)
          ph_d = PH_IDLE;
        else if (cas_rise)
          ph_d = PH_PAGE;
        else if (we_fall && !early_q)
          mem_we = 1'b1;
      end
      PH_RFSH: begin
        if (ras_rise)
          ph_d = PH_IDLE;
        else if (cas_fall)
          err_d = 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      valid_q <= 1'b0;
      early_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      row_q   <= row_d;
      col_q   <= col_d;
      valid_q <= valid_d;
      early_q <= early_d;
      err_q   <= err_d;
    end
  end

  assert_write_strobes_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (!cas_n && !ras_n && !we_n));

  assert_refresh_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_RFSH) |-> !mem_we);

  assert_err_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q);

  assert_open_row_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_COL || ph_q == PH_PAGE) |-> $stable(row_q));

endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int DATA_W = 4,
  parameter int DEPTH  = 1024,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[idx] <= wr_data;
  end

  assign rd_data = cells[idx];

endmodule

// File: rtl/dram_out_stage.sv
module dram_out_stage #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_load,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              valid_q,
  input  logic              early_q,
  input  logic              oe_q,
  input  logic              cas_q,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_q <= '0;
    else if (rd_load)
      hold_q <= rd_data;
  end

  assign dout_en = valid_q & ~oe_q;
  assign dout    = dout_en ? hold_q : '0;

  assert_early_write_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> !early_q);

  assert_drive_needs_cas_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> !cas_q);

  assert_hidden_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && $past(valid_q)) |-> $stable(hold_q));

endmodule

// File: rtl/dram_fn_model.sv
module dram_fn_model #(
  parameter int ADDR_W        = 9,
  parameter int DATA_W        = 4,
  parameter int DEPTH         = 1024,
  parameter int PRECHARGE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              proto_err
);

  localparam int IDX_W = $clog2(DEPTH);

  logic ras_q, cas_q, oe_q;
  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall, pre_ok;
  logic mem_we, rd_load, valid_q, early_q;
  logic [IDX_W-1:0]  mem_idx;
  logic [DATA_W-1:0] rd_data;

  dram_strobe_sampler #(.PRECHARGE_CYC(PRECHARGE_CYC)) u_smp (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .ras_q(ras_q), .cas_q(cas_q), .oe_q(oe_q),
    .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_fall(cas_fall),
    .cas_rise(cas_rise), .we_fall(we_fall), .pre_ok(pre_ok)
  );

  dram_cycle_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .cas_q(cas_q), .ras_fall(ras_fall), .ras_rise(ras_rise),
    .cas_fall(cas_fall), .cas_rise(cas_rise), .we_fall(we_fall),
    .pre_ok(pre_ok), .mem_we(mem_we), .mem_idx(mem_idx), .rd_load(rd_load),
    .valid_q(valid_q), .early_q(early_q), .err_q(proto_err)
  );

  dram_cell_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_arr (
    .clk(clk), .wr_en(mem_we), .idx(mem_idx), .wr_data(din), .rd_data(rd_data)
  );

  dram_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .rd_load(rd_load), .rd_data(rd_data),
    .valid_q(valid_q), .early_q(early_q), .oe_q(oe_q), .cas_q(cas_q),
    .dout(dout), .dout_en(dout_en)
  );

  assert_row_strobe_seen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ras_fall |=> !ras_q);

endmodule

// File: tb/tb_dram_fn_model.sv
module tb_dram_fn_model;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [8:0] addr = '0;
  logic [3:0] din = '0;
  logic [3:0] dout;
  logic       dout_en, proto_err;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  dram_fn_model dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .proto_err(proto_err)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (n) tick();
  endtask

  task automatic wr_early(input logic [8:0] r, input logic [8:0] c, input logic [3:0] d);
    idle(2);
    addr = r; ras_n = 1'b0; tick();
    addr = c; we_n = 1'b0; din = d; oe_n = 1'b0; cas_n = 1'b0; tick();
    chk("R7 early write hiz", {7'd0, dout_en}, 8'd0);
    tick();
    chk("R7 early write hiz later", {7'd0, dout_en}, 8'd0);
    idle(2);
  endtask

  task automatic rd(input logic [8:0] r, input logic [8:0] c, input logic [3:0] exp, input string req);
    idle(2);
    addr = r; ras_n = 1'b0; oe_n = 1'b0; tick();
    chk({req, " hiz before column"}, {7'd0, dout_en}, 8'd0);
    addr = c; din = ~exp; cas_n = 1'b0; tick();
    chk({req, " read enable"}, {7'd0, dout_en}, 8'd1);
    chk({req, " read data"}, {4'd0, dout}, {4'd0, exp});
    cas_n = 1'b1; tick();
    chk({req, " release on cas high"}, {7'd0, dout_en}, 8'd0);
    idle(2);
  endtask

  task automatic t_reset();
    chk("R1 dout_en", {7'd0, dout_en}, 8'd0);
    chk("R1 proto_err", {7'd0, proto_err}, 8'd0);
    chk("R1 dout", {4'd0, dout}, 8'd0);
  endtask

  task automatic t_write_read();
    wr_early(9'd1, 9'd5, 4'hA);
    rd(9'd1, 9'd5, 4'hA, "R3 R2 R5");
    rd(9'd1, 9'd5, 4'hA, "R6 din ignored");
  endtask

  task automatic t_oe_release();
    idle(2);
    addr = 9'd1; ras_n = 1'b0; tick();
    addr = 9'd5; cas_n = 1'b0; oe_n = 1'b0; tick();
    chk("R5 oe low drive", {7'd0, dout_en}, 8'd1);
    oe_n = 1'b1; tick();
    chk("R5 oe high release", {7'd0, dout_en}, 8'd0);
    chk("R5 dout zero when released", {4'd0, dout}, 8'd0);
    oe_n = 1'b0; tick();
    chk("R5 oe low again", {4'd0, dout}, 8'h0A);
    idle(2);
  endtask

  task automatic t_delayed();
    idle(2);
    addr = 9'd0; ras_n = 1'b0; tick();
    addr = 9'h12; cas_n = 1'b0; tick();
    chk("R4 delayed write oe high", {7'd0, dout_en}, 8'd0);
    din = 4'hC; we_n = 1'b0; tick();
    idle(2);
    rd(9'd0, 9'h12, 4'hC, "R4 delayed write");
    wr_early(9'd0, 9'h20, 4'h3);
    addr = 9'd0; ras_n = 1'b0; tick();
    addr = 9'h20; cas_n = 1'b0; oe_n = 1'b0; tick();
    chk("R4 rmw old data", {4'd0, dout}, 8'h03);
    oe_n = 1'b1; tick();
    din = 4'h8; we_n = 1'b0; tick();
    idle(2);
    rd(9'd0, 9'h20, 4'h8, "R4 rmw new data");
  endtask

  task automatic t_alias();
    wr_early(9'd4, 9'd7, 4'h3);
    wr_early(9'd6, 9'd7, 4'h9);
    rd(9'd4, 9'd7, 4'h9, "R2 row alias");
    wr_early(9'd5, 9'd7, 4'h5);
    rd(9'd4, 9'd7, 4'h9, "R2 row bit0 distinct");
    rd(9'd7, 9'd7, 4'h5, "R2 odd alias");
  endtask

  task automatic t_page();
    wr_early(9'd2, 9'd1, 4'h4);
    wr_early(9'd2, 9'd2, 4'h7);
    idle(2);
    addr = 9'd2; ras_n = 1'b0; tick();
    addr = 9'd1; cas_n = 1'b0; oe_n = 1'b0; tick();
    chk("R11 page col1", {4'd0, dout}, 8'h04);
    cas_n = 1'b1; tick();
    chk("R11 page precharge hiz", {7'd0, dout_en}, 8'd0);
    addr = 9'd2; cas_n = 1'b0; tick();
    chk("R11 page col2", {4'd0, dout}, 8'h07);
    cas_n = 1'b1; tick();
    addr = 9'd3; we_n = 1'b0; din = 4'hB; cas_n = 1'b0; tick();
    chk("R11 R7 page write hiz", {7'd0, dout_en}, 8'd0);
    cas_n = 1'b1; we_n = 1'b1; tick();
    idle(2);
    rd(9'd2, 9'd3, 4'hB, "R11 page write");
  endtask

  task automatic t_ras_only();
    idle(2);
    addr = 9'd1; ras_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; din = 4'hF;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R9 row-only refresh hiz", {7'd0, dout_en}, 8'd0);
    end
    idle(2);
    rd(9'd1, 9'd5, 4'hA, "R9 row-only refresh keeps data");
  endtask

  task automatic t_cbr();
    idle(2);
    cas_n = 1'b0; tick();
    chk("R12 precharged cas fall no error", {7'd0, proto_err}, 8'd0);
    addr = 9'd5; ras_n = 1'b0; we_n = 1'b0; din = 4'hE; oe_n = 1'b0; tick();
    chk("R8 refresh hiz", {7'd0, dout_en}, 8'd0);
    chk("R8 refresh no error", {7'd0, proto_err}, 8'd0);
    tick();
    ras_n = 1'b1; tick();
    idle(2);
    rd(9'd1, 9'd5, 4'hA, "R8 refresh keeps data");
  endtask

  task automatic t_hidden();
    idle(2);
    addr = 9'd1; ras_n = 1'b0; tick();
    addr = 9'd5; cas_n = 1'b0; oe_n = 1'b0; tick();
    chk("R10 initial read", {4'd0, dout}, 8'h0A);
    ras_n = 1'b1; tick();
    chk("R10 after row rise", {3'd0, dout_en, dout}, 8'h1A);
    ras_n = 1'b0; tick();
    chk("R10 during refresh", {3'd0, dout_en, dout}, 8'h1A);
    chk("R10 no error", {7'd0, proto_err}, 8'd0);
    tick();
    ras_n = 1'b1; tick();
    chk("R10 after refresh", {3'd0, dout_en, dout}, 8'h1A);
    cas_n = 1'b1; tick();
    chk("R10 cas high releases", {7'd0, dout_en}, 8'd0);
    idle(2);
  endtask

  task automatic t_err_precharge();
    idle(2);
    cas_n = 1'b0; tick();
    chk("R12 first fall ok", {7'd0, proto_err}, 8'd0);
    cas_n = 1'b1; tick();
    cas_n = 1'b0; tick();
    chk("R12 short precharge", {7'd0, proto_err}, 8'd1);
    tick();
    chk("R12 single pulse", {7'd0, proto_err}, 8'd0);
    idle(2);
  endtask

  task automatic t_err_norow();
    wr_early(9'd3, 9'd9, 4'h6);
    idle(2);
    addr = 9'd3; cas_n = 1'b0; tick();
    ras_n = 1'b0; tick();
    cas_n = 1'b1; tick();
    addr = 9'd9; we_n = 1'b0; din = 4'h1; oe_n = 1'b0; cas_n = 1'b0; tick();
    chk("R13 no row error", {7'd0, proto_err}, 8'd1);
    chk("R13 no drive", {7'd0, dout_en}, 8'd0);
    tick();
    chk("R13 single pulse", {7'd0, proto_err}, 8'd0);
    idle(2);
    rd(9'd3, 9'd9, 4'h6, "R13 no write");
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_write_read();
    t_oe_release();
    t_delayed();
    t_alias();
    t_page();
    t_ras_only();
    t_cbr();
    t_hidden();
    t_err_precharge();
    t_err_norow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule